// File: doc/BRIEF.md
# Real-Power Multiply and Filter Datapath

This block turns a stream of signed current and voltage samples into a signed real-power word. A one-pole high-pass stage strips the DC level from the current samples only. Once one factor carries no DC, a DC offset on the other factor cannot leave a constant error term in the product. The block multiplies the filtered current by the voltage sample of the same instant. A slow exponential averager then keeps the DC part of that product, which is the real power, and suppresses the ripple at twice the line frequency.

Samples enter with a strobe at the oversampled rate, nominally 450 kHz. Each accepted pair produces one output word with a valid pulse a fixed three cycles later. The pipeline only advances on strobes, so idle clocks between samples leave every stage untouched. The output keeps its sign, so a later block can flag reversed power flow. With the default averager shift of 14, the corner frequency is near 4.4 Hz at 450 kHz, and the 100 Hz ripple is about 27 dB down.

Top module: `real_power_dp`

## Requirements
- R1: While rst_ni is low and after it is released, before any strobe, pwr_vld_o is 0 and pwr_o is 0.
- R2: On each strobe the current filter state y updates as y = y + x - x_prev - (y >>> HPF_K), with x the new current sample, x_prev the previous accepted current sample, and x_prev and y both 0 after reset.
- R3: The instantaneous power of a sample is the filtered current from R2 times the voltage sample of the same strobe, with no filtering applied to the voltage.
- R4: On each product the averager state a updates as a = a + p - (a >>> LPF_M), and pwr_o equals a >>> LPF_M as a signed PW-bit value, PW = 2*DW+2.
- R5: pwr_vld_o is high exactly 3 clock cycles after each cycle in which smp_vld_i is sampled high, and is low otherwise.
- R6: Cycles without smp_vld_i change no filter state, and pwr_o holds its last value.
- R7: A current in phase with the voltage yields a positive pwr_o once settled, and a current in antiphase yields a negative pwr_o.
- R8: A constant current sample is rejected: its filtered value decays below 2^HPF_K in magnitude, so the settled |pwr_o| stays under 2^HPF_K * 2^(DW-1).
- R9: The filtered current never exceeds 2^DW + 2^HPF_K in magnitude, and no internal sum or product wraps for any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Sample strobe, one per sample pair |
| cur_i | input | DW | Signed current-channel sample |
| vol_i | input | DW | Signed voltage-channel sample |
| pwr_vld_o | output | 1 | Output valid pulse |
| pwr_o | output | 2*DW+2 | Signed filtered real power |

## Verification
The bench sweeps every pair of 6-bit current and voltage codes through a small configuration, with idle gaps. Each output word is checked against a reference recurrence computed in the bench. A filter that shifted logically instead of arithmetically would drift the wrong way on negative values. A stage that advanced during idle cycles would smear samples, and a mistimed voltage register would pair each current with the wrong voltage. All three show up as mismatched words or broken hold values. Separate runs hold the current at a constant level, to check that a high-pass stage that leaks DC is caught. Further runs drive the current in phase and in antiphase with the voltage, to catch a datapath that drops the sign. Every pulse is timed against its strobe, so a pipeline that is one register short or one register long fails at once.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  function automatic int hpf_width(input int dw);
    return dw + 2;
  endfunction

  function automatic int pwr_width(input int dw);
    return 2 * dw + 2;
  endfunction
endpackage

// File: rtl/rpd_hpf.sv
module rpd_hpf #(
  parameter int DW = 16,
  parameter int K  = 10,
  localparam int HW = rpd_pkg::hpf_width(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] x_i,
  output logic                 vld_o,
  output logic signed [HW-1:0] y_o
);
  localparam logic signed [HW:0] BOUND = (HW+1)'(1 << DW) + (HW+1)'(1 << K);

  logic signed [HW-1:0] x_prev_q, y_q, x_ext, y_nxt;

  assign x_ext = HW'(x_i);
  assign y_nxt = y_q + x_ext - x_prev_q - (y_q >>> K);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_prev_q <= '0;
      y_q      <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        x_prev_q <= x_ext;
        y_q      <= y_nxt;
      end
    end
  end

  assign y_o = y_q;

  // R9: filtered current stays inside its analytic bound
  a_r9_hpf_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((HW+1)'(y_q) <= BOUND) && ((HW+1)'(y_q) >= -BOUND));

  // R6: no strobe, no state change
  a_r6_hpf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(y_q) && $stable(x_prev_q));
endmodule

// File: rtl/rpd_mul.sv
module rpd_mul #(
  parameter int AW = 18,
  parameter int BW = 16,
  localparam int PW = AW + BW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic                 vld_o,
  output logic signed [PW-1:0] p_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) p_o <= PW'(a_i) * PW'(b_i);
    end
  end

  // R3: a zero operand gives a zero product
  a_r3_zero_prod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && (a_i == '0 || b_i == '0) |=> p_o == '0);

  // R6: product register holds between strobes
  a_r6_mul_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(p_o));
endmodule

// File: rtl/rpd_lpf.sv
module rpd_lpf #(
  parameter int PW = 34,
  parameter int M  = 14,
  localparam int AW = PW + M + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [PW-1:0] p_i,
  output logic                 vld_o,
  output logic signed [PW-1:0] y_o
);
  logic signed [AW-1:0] acc_q, p_ext, acc_nxt;

  assign p_ext   = AW'(p_i);
  assign acc_nxt = acc_q + p_ext - (acc_q >>> M);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) acc_q <= acc_nxt;
    end
  end

  assign y_o = acc_q[M+PW-1:M];

  // R6: averager state holds between strobes
  a_r6_lpf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_q));

  // R9: top guard bits agree, so the output slice does not wrap
  a_r9_lpf_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q[AW-1] == acc_q[AW-2]);
endmodule

// File: rtl/real_power_dp.sv
module real_power_dp #(
  parameter int DW     = 16,
  parameter int HPF_K  = 10,
  parameter int LPF_M  = 14,
  localparam int HW = rpd_pkg::hpf_width(DW),
  localparam int PW = rpd_pkg::pwr_width(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_vld_i,
  input  logic signed [DW-1:0] cur_i,
  input  logic signed [DW-1:0] vol_i,
  output logic                 pwr_vld_o,
  output logic signed [PW-1:0] pwr_o
);
  logic                 s1_vld, s2_vld;
  logic signed [HW-1:0] cur_f;
  logic signed [DW-1:0] vol_q;
  logic signed [PW-1:0] prod;

  // voltage aligned with the filtered current sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vol_q <= '0;
    else if (smp_vld_i) vol_q <= vol_i;
  end

  rpd_hpf #(.DW(DW), .K(HPF_K)) u_hpf (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i), .x_i(cur_i),
    .vld_o(s1_vld), .y_o(cur_f)
  );

  rpd_mul #(.AW(HW), .BW(DW)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(s1_vld), .a_i(cur_f), .b_i(vol_q),
    .vld_o(s2_vld), .p_o(prod)
  );

  rpd_lpf #(.PW(PW), .M(LPF_M)) u_lpf (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(s2_vld), .p_i(prod),
    .vld_o(pwr_vld_o), .y_o(pwr_o)
  );

  // R5: fixed three-cycle latency, one pulse per strobe
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |-> ##3 pwr_vld_o);
  a_r5_no_spur: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |-> ##3 !pwr_vld_o);
endmodule

// File: tb/real_power_dp_tb.sv
module real_power_dp_tb;
  localparam int DW = 6;
  localparam int K  = 3;
  localparam int M  = 4;
  localparam int PW = 2 * DW + 2;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic signed [DW-1:0] cur = '0, vol = '0;
  logic pwr_vld;
  logic signed [PW-1:0] pwr;

  real_power_dp #(.DW(DW), .HPF_K(K), .LPF_M(M)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .cur_i(cur), .vol_i(vol),
    .pwr_vld_o(pwr_vld), .pwr_o(pwr)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint m_y, m_xp, m_acc, last_out, e_val, e_stamp;
  longint exp_q[$];
  longint stamp_q[$];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; vld = 1'b0;
    m_y = 0; m_xp = 0; m_acc = 0; last_out = 0;
    exp_q.delete(); stamp_q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwr_vld == 1'b0 && pwr == '0, "R1 in reset", longint'(pwr), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(pwr_vld == 1'b0 && pwr == '0, "R1 after release", longint'(pwr), 0);
  endtask

  // reference recurrences of R2, R3, R4
  task automatic send(input int c, input int v);
    longint p;
    @(posedge clk); #1;
    vld = 1'b1; cur = DW'(c); vol = DW'(v);
    m_y  = m_y + (longint'(c) - m_xp) - (m_y >>> K);
    m_xp = c;
    p = m_y * v;
    m_acc = m_acc + p - (m_acc >>> M);
    exp_q.push_back(m_acc >>> M);
    stamp_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1; vld = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pwr_vld) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 spurious valid", 1, 0);
        else begin
          e_val = exp_q.pop_front();
          e_stamp = stamp_q.pop_front();
          chk(longint'(pwr) == e_val, "R2 R3 R4 power word", longint'(pwr), e_val);
          chk(cyc - e_stamp == 3, "R5 latency", cyc - e_stamp, 3);
          last_out = longint'(pwr);
        end
      end else begin
        chk(longint'(pwr) == last_out, "R6 hold when idle", longint'(pwr), last_out);
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R2 R3 R4 R6 R9: full sweep of both channels with idle gaps
    n = 0;
    for (int c = -(1 << (DW-1)); c < (1 << (DW-1)); c++) begin
      for (int v = -(1 << (DW-1)); v < (1 << (DW-1)); v++) begin
        send(c, v);
        n++;
        if (n % 7 == 0) idle(n % 3 + 1);
      end
    end
    idle(6);
    chk(exp_q.size() == 0, "R5 one pulse per strobe", exp_q.size(), 0);

    // R8: constant current is rejected
    do_reset();
    for (int i = 0; i < 200; i++) send(31, 31);
    idle(6);
    chk(pwr < 256 && pwr > -256, "R8 DC current rejected", longint'(pwr), 255);

    // R7: in phase gives positive power
    do_reset();
    for (int i = 0; i < 300; i++) send((i % 2) ? 20 : -20, (i % 2) ? 20 : -20);
    idle(6);
    chk(pwr > 0, "R7 positive power", longint'(pwr), 1);
    // R7: antiphase gives negative power
    for (int i = 0; i < 300; i++) send((i % 2) ? -20 : 20, (i % 2) ? 20 : -20);
    idle(6);
    chk(pwr < 0, "R7 negative power", longint'(pwr), -1);

    // R9: extreme steps on the current channel
    do_reset();
    for (int i = 0; i < 100; i++) send((i % 2) ? 31 : -32, -32);
    idle(6);
    chk(exp_q.size() == 0, "R9 extreme steps drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule